// File: doc/BRIEF.md
# Change-Triggered Interrupt Collector

This block watches a vector of status conditions and turns each change of an enabled condition into a sticky pending bit. A single interrupt line is raised while any pending bit is set. Software uses a small register port to read the pending bits and to enable each condition. It clears pending bits one at a time by writing ones to a self-clearing clear register. It can also drop every pending bit at once, either with a self-clearing control bit or with a dedicated hardware clear input.

Only transitions count. A condition that is already high or low when it is enabled stays silent. A condition that is still held after its pending bit was cleared also stays silent. Each condition must move again before it raises anything. The register port is a plain synchronous write strobe with an address, plus a combinational read-data output. Bus protocol decoding is left to the surrounding logic.

Top module: `chg_irq_collector`

## Requirements
- R1: An enabled condition whose level at a clock edge differs from its level at the previous edge sets its pending bit at that edge. Rising and falling changes both count.
- R2: A condition that holds a steady level raises nothing. This covers a level that was already present when the enable was written, and a level still held after its pending bit was cleared.
- R3: A register write to address 2 clears, at that edge, every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R4: Reads of address 2 (bit clear) and address 3 (control) always return zero, because both registers clear themselves after the write.
- R5: Writing 1 to bit 0 of address 3 clears every pending bit at that edge.
- R6: When the hardware clear input is high at a clock edge, every pending bit is cleared at that edge.
- R7: The interrupt output equals the OR of all pending bits, one clock after them. It stays high until every pending bit has been cleared.
- R8: When a change event and a clear (bitwise, control or hardware) hit the same bit at the same edge, the event wins and the bit ends up set.
- R9: A pending bit whose enable is 0 is never set. Writing 0 to an enable also clears that bit's pending state at the write edge, so clear writes to a disabled bit have no effect.
- R10: Address 1 holds the per-condition enables and reads back the value last written. Address 0 reads the pending bits.
- R11: After synchronous reset, the pending bits, the enables and the interrupt output are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | N_SRC | Monitored status conditions, synchronous to clk |
| hw_clr_i | input | 1 | Hardware request to clear all pending bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 pending, 1 enable, 2 bit clear, 3 control |
| reg_wdata_i | input | N_SRC | Register write data |
| reg_rdata_o | output | N_SRC | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt, high while any pending bit is set |

## Verification
The bench builds the collector with N_SRC set to 8. At that width a single pattern can flip every condition at once, so an all-ones pending word and a full global clear are easy to reach. Mixed patterns such as 0xA5 and 0x0F show that enables, clears and events stay confined to their own bits. The default width of 16 uses the same per-bit logic, so the narrower build still reaches every corner: collisions, disabling a set bit, and re-enabling while a level is held.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    // Register selector carried on reg_addr_i
    typedef enum logic [1:0] {
        REG_PEND   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_BITCLR = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    localparam int SEL_W        = 2;
    localparam int CTRL_ALL_BIT = 0;

    // Decoded write strobes for one cycle
    typedef struct packed {
        logic en_wr;
        logic bit_clr;
        logic all_clr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(logic wr, logic [SEL_W-1:0] addr,
                                                logic ctrl_bit);
        wr_strobe_t s;
        s.en_wr   = wr && (reg_sel_e'(addr) == REG_ENABLE);
        s.bit_clr = wr && (reg_sel_e'(addr) == REG_BITCLR);
        s.all_clr = wr && (reg_sel_e'(addr) == REG_CTRL) && ctrl_bit;
        return s;
    endfunction

endpackage

// File: rtl/chg_irq_regs.sv
module chg_irq_regs
    import chg_irq_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_i,
    input  logic [SEL_W-1:0] reg_addr_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    input  logic             hw_clr_i,
    input  logic [N_SRC-1:0] pend_q,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] en_d,
    output logic [N_SRC-1:0] clr_bits,
    output logic             clr_all,
    output logic [N_SRC-1:0] reg_rdata_o
);
    wr_strobe_t st;

    always_comb begin
        st       = decode_write(reg_wr_i, reg_addr_i, reg_wdata_i[CTRL_ALL_BIT]);
        en_d     = st.en_wr ? reg_wdata_i : en_q;
        clr_bits = st.bit_clr ? reg_wdata_i : '0;
        clr_all  = st.all_clr || hw_clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    // Self-clearing registers hold no storage and read as zero
    always_comb begin
        unique case (reg_sel_e'(reg_addr_i))
            REG_PEND:   reg_rdata_o = pend_q;
            REG_ENABLE: reg_rdata_o = en_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    // R4
    selfclr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == REG_BITCLR || reg_addr_i == REG_CTRL) |-> reg_rdata_o == '0);

    // R10
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == REG_ENABLE) |=> en_q == $past(reg_wdata_i));

endmodule

// File: rtl/chg_irq_detect.sv
module chg_irq_detect #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] cond_i,
    input  logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] evt
);
    logic [N_SRC-1:0] samp_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // Baseline is refreshed every cycle, also in reset, so after enabling
        // or clearing it always equals the present level.
        always_ff @(posedge clk) begin
            samp_q[i] <= cond_i[i];
        end
        assign evt[i] = en_q[i] & (cond_i[i] ^ samp_q[i]);
    end

    // R2
    steady_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i == $past(cond_i)) |-> evt == '0);

endmodule

// File: rtl/chg_irq_latch.sv
module chg_irq_latch #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] en_q,
    input  logic [N_SRC-1:0] en_d,
    input  logic [N_SRC-1:0] clr_bits,
    input  logic             clr_all,
    output logic [N_SRC-1:0] pend_q,
    output logic             irq_o
);
    logic [N_SRC-1:0] clr_mask;
    logic [N_SRC-1:0] pend_d;

    always_comb begin
        clr_mask = clr_all ? '1 : clr_bits;
        // Event is OR-ed after the clear so it wins a collision
        pend_d   = ((pend_q & ~clr_mask) | evt) & en_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_o  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_o  <= |pend_q;
        end
    end

    // R8
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt & en_d) != '0) |=> (pend_q & $past(evt & en_d)) == $past(evt & en_d));

    // R5
    global_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (pend_q & ~$past(evt)) == '0);

    // R7
    irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |=> irq_o);

    // R7
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |=> !irq_o);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~en_q) == '0);

endmodule

// File: rtl/chg_irq_collector.sv
module chg_irq_collector
    import chg_irq_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] cond_i,
    input  logic             hw_clr_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    output logic [N_SRC-1:0] reg_rdata_o,
    output logic             irq_o
);
    logic [N_SRC-1:0] en_q, en_d, clr_bits, evt, pend_q;
    logic             clr_all;

    chg_irq_regs #(.N_SRC(N_SRC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr_i   (reg_wr_i),
        .reg_addr_i (reg_addr_i),
        .reg_wdata_i(reg_wdata_i),
        .hw_clr_i   (hw_clr_i),
        .pend_q     (pend_q),
        .en_q       (en_q),
        .en_d       (en_d),
        .clr_bits   (clr_bits),
        .clr_all    (clr_all),
        .reg_rdata_o(reg_rdata_o)
    );

    chg_irq_detect #(.N_SRC(N_SRC)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .cond_i(cond_i),
        .en_q  (en_q),
        .evt   (evt)
    );

    chg_irq_latch #(.N_SRC(N_SRC)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .en_q    (en_q),
        .en_d    (en_d),
        .clr_bits(clr_bits),
        .clr_all (clr_all),
        .pend_q  (pend_q),
        .irq_o   (irq_o)
    );

    // R6
    hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hw_clr_i |=> (reg_addr_i != 2'd0) || ((reg_rdata_o & ~$past(evt)) == '0));

endmodule

// File: tb/chg_irq_collector_tb.sv
module chg_irq_collector_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] cond_i = '0;
    logic         hw_clr_i = 1'b0;
    logic         reg_wr_i = 1'b0;
    logic [1:0]   reg_addr_i = 2'd0;
    logic [N-1:0] reg_wdata_i = '0;
    logic [N-1:0] reg_rdata_o;
    logic         irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    chg_irq_collector #(.N_SRC(N)) u_dut (
        .clk(clk), .rst(rst), .cond_i(cond_i), .hw_clr_i(hw_clr_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
        reg_addr_i = a;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic set_cond(input logic [N-1:0] v);
        cond_i = v;
        tick();
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        rd(2'd0, v); check("R11 pending", v, 0);
        rd(2'd1, v); check("R11 enable", v, 0);
        check("R11 irq", irq_o, 0);
    endtask

    task automatic t_enable_rw();
        logic [N-1:0] v;
        wr(2'd1, 8'hA5);
        rd(2'd1, v); check("R10 enable readback", v, 8'hA5);
        wr(2'd1, 8'h00);
        set_cond(8'h0F);            // toggles while disabled
        rd(2'd0, v); check("R9 disabled no set", v, 0);
    endtask

    task automatic t_preexisting();
        logic [N-1:0] v;
        wr(2'd1, 8'hFF);            // cond already 0x0F
        tick(); tick();
        rd(2'd0, v); check("R2 pre-existing level", v, 0);
        check("R2 irq quiet", irq_o, 0);
    endtask

    task automatic t_changes();
        logic [N-1:0] v;
        set_cond(8'h1F);            // bit4 rises
        rd(2'd0, v); check("R1 rise", v, 8'h10);
        check("R7 irq lags", irq_o, 0);
        tick();
        check("R7 irq high", irq_o, 1);
        set_cond(8'h1E);            // bit0 falls
        rd(2'd0, v); check("R1 fall", v, 8'h11);
    endtask

    task automatic t_bit_clear();
        logic [N-1:0] v;
        wr(2'd2, 8'h01);
        rd(2'd0, v); check("R3 single clear", v, 8'h10);
        tick();
        check("R7 irq held", irq_o, 1);
        rd(2'd2, v); check("R4 clear reads zero", v, 0);
        rd(2'd3, v); check("R4 ctrl reads zero", v, 0);
        tick();
        rd(2'd0, v); check("R2 no re-raise", v, 8'h10);
        wr(2'd2, 8'h10);
        rd(2'd0, v); check("R3 last clear", v, 0);
        check("R7 irq one late", irq_o, 1);
        tick();
        check("R7 irq low", irq_o, 0);
    endtask

    task automatic t_global();
        logic [N-1:0] v;
        set_cond(8'hE1);            // every bit flips
        rd(2'd0, v); check("R1 all bits", v, 8'hFF);
        wr(2'd3, 8'h01);
        rd(2'd0, v); check("R5 ctrl clear", v, 0);
        set_cond(8'h1E);
        rd(2'd0, v); check("R1 all flip back", v, 8'hFF);
        hw_clr_i = 1'b1; tick(); hw_clr_i = 1'b0;
        rd(2'd0, v); check("R6 hw clear", v, 0);
    endtask

    task automatic t_collision();
        logic [N-1:0] v;
        set_cond(8'h1A);            // bit2 falls
        // bit2 rises again while it is cleared by the register
        cond_i = 8'h1E;
        wr(2'd2, 8'h04);
        rd(2'd0, v); check("R8 event beats bit clear", v, 8'h04);
        // bit3 flips while hardware clear is high
        cond_i = 8'h16; hw_clr_i = 1'b1; tick(); hw_clr_i = 1'b0;
        rd(2'd0, v); check("R8 event beats hw clear", v, 8'h08);
    endtask

    task automatic t_disable();
        logic [N-1:0] v;
        set_cond(8'hE6);            // bits 7..4 flip
        rd(2'd0, v); check("R1 upper set", v, 8'hF8);
        wr(2'd1, 8'h0F);
        rd(2'd0, v); check("R9 disable drops bits", v, 8'h08);
        set_cond(8'h66);            // bit7 flips while disabled
        rd(2'd0, v); check("R9 disabled stays 0", v, 8'h08);
        wr(2'd2, 8'hF0);
        rd(2'd0, v); check("R9 clear of disabled no effect", v, 8'h08);
        wr(2'd1, 8'hFF);
        tick();
        rd(2'd0, v); check("R2 re-enable held level", v, 8'h08);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_enable_rw();
        t_preexisting();
        t_changes();
        t_bit_clear();
        t_global();
        t_collision();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule